// File: doc/BRIEF.md
# Pixel Colour Depth Formatter

This block sits between the pixel pipeline and a flat-panel interface. It takes a pixel made of three 8-bit colour components and produces the component width that the panel expects, which may be anywhere from 3 to 10 bits. For a narrower panel it either keeps only the upper bits of each component, or it dithers. Dithering rounds a component up by one output step when the bits being dropped exceed a threshold. That threshold comes from a 4x4 ordered matrix, addressed by the pixel position and shifted every frame. For a wider panel it either repeats the top bits of each component in the new low bits, or leaves them at zero.

The output width and the two mode enables are captured only on a frame-start strobe, so the format never changes partway through a picture. Every accepted pixel comes out exactly one clock later, with its valid flag registered alongside it.

Top module: `pixel_depth_formatter`

## Requirements
- R1: `outValid` is high in the cycle after each cycle in which `inValid` is high, and low otherwise. `outPixel` is registered on the same edge. After reset, `outValid` and `outPixel` are both zero.
- R2: While `inValid` is low, `outPixel` keeps its last value, whatever the other inputs do.
- R3: The format settings are captured only at a clock edge where `frameStart` is high. They take effect for pixels presented in later cycles. A requested width below 3 is treated as 3, and one above 10 as 10. After reset the width is 8, with dithering and replication both off.
- R4: The input carries red in `inPixel[23:16]`, green in `[15:8]` and blue in `[7:0]`. The output carries red in `outPixel[29:20]`, green in `[19:10]` and blue in `[9:0]`, each right-aligned in its lane. Lane bits at or above the active width are zero.
- R5: When the width W is below 8 and dithering is off, each output component is the top W bits of the input component.
- R6: When W is below 8 and dithering is on, let D = 8 - W. The threshold T is taken from the 4x4 matrix, rows listed top to bottom: (0 8 2 10), (12 4 14 6), (3 11 1 9), (15 7 13 5). The column is (x[1:0] + f[1:0]) mod 4 and the row is (y[1:0] + f[1:0]) mod 4, where f is `frameNum`. T is shifted right by 4-D when D is 4 or less, and left by D-4 when D is 5. The output is the top W bits, plus one when the low D bits are strictly greater than T.
- R7: Dither rounding saturates: a component whose top W bits are all ones is never incremented.
- R8: When W is above 8 and replication is on, the component is shifted up by E = W - 8 bits, and its top E bits fill the new low bits.
- R9: When W is above 8 and replication is off, the new low E bits are zero. When W is above 8, dithering has no effect. When W equals 8, the component passes through unchanged whatever the enables are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| frameStart | input | 1 | Strobe that captures the format settings |
| cfgOutWidth | input | 4 | Requested output component width |
| cfgDitherEn | input | 1 | Enable dithering when reducing |
| cfgReplicateEn | input | 1 | Enable MSB replication when expanding |
| inValid | input | 1 | Input pixel qualifier |
| inPixel | input | 24 | Input pixel, red/green/blue, 8 bits each |
| posX | input | 12 | Pixel column |
| posY | input | 12 | Pixel row |
| frameNum | input | 8 | Frame counter |
| outValid | output | 1 | Output pixel qualifier |
| outPixel | output | 30 | Output pixel, three 10-bit lanes |

## Verification
Every pixel result appears exactly one clock edge after the cycle in which it was presented with `inValid` high. The bench drives on the falling edge and compares `outPixel` and `outValid` on the next falling edge, which is the single register stage. A settings change is due from the first pixel presented after the `frameStart` cycle. The bench therefore spends one full cycle on `frameStart` before sending pixels, and it also sends pixels with changed settings but no strobe, to confirm they are not taken up. The hold behaviour is checked over several idle cycles that follow a result.

// File: rtl/pdf_pkg.sv
package pdf_pkg;
  localparam int COMP_W    = 8;
  localparam int NUM_COMP  = 3;
  localparam int MAX_OUT_W = 10;
  localparam int MIN_OUT_W = 3;
  localparam int WSEL_W    = 4;
  localparam int DROP_W    = 3;
  localparam int EXTRA_W   = 2;
  localparam int THR_W     = 4;

  typedef enum logic [2:0] {
    MODE_PASS   = 3'd0,
    MODE_TRUNC  = 3'd1,
    MODE_DITHER = 3'd2,
    MODE_REPL   = 3'd3,
    MODE_PAD    = 3'd4
  } fmtMode_e;

  // strobes from control to datapath
  typedef struct packed {
    fmtMode_e                mode;
    logic [WSEL_W-1:0]       outWidth;
    logic [DROP_W-1:0]       dropBits;
    logic [EXTRA_W-1:0]      extraBits;
    logic                    load;
  } fmtCtrl_t;

  // ordered 4x4 threshold built from bit interleaving
  function automatic logic [THR_W-1:0] orderedThreshold(input logic [1:0] col,
                                                        input logic [1:0] row);
    logic [1:0] mix;
    mix = col ^ row;
    return {mix[0], row[0], mix[1], row[1]};
  endfunction
endpackage

// File: rtl/pdf_ctrl.sv
module pdf_ctrl
  import pdf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStart,
  input  logic [WSEL_W-1:0] cfgOutWidth,
  input  logic              cfgDitherEn,
  input  logic              cfgReplicateEn,
  input  logic              inValid,
  output fmtCtrl_t          ctrlS
);
  localparam logic [WSEL_W-1:0] NATIVE_W = WSEL_W'(COMP_W);
  localparam logic [WSEL_W-1:0] LOW_W    = WSEL_W'(MIN_OUT_W);
  localparam logic [WSEL_W-1:0] HIGH_W   = WSEL_W'(MAX_OUT_W);

  logic [WSEL_W-1:0] clampedWidth;
  logic [WSEL_W-1:0] widthQ;
  logic              ditherQ;
  logic              replQ;

  always_comb begin
    if (cfgOutWidth < LOW_W)       clampedWidth = LOW_W;
    else if (cfgOutWidth > HIGH_W) clampedWidth = HIGH_W;
    else                           clampedWidth = cfgOutWidth;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      widthQ  <= NATIVE_W;
      ditherQ <= 1'b0;
      replQ   <= 1'b0;
    end else if (frameStart) begin
      widthQ  <= clampedWidth;
      ditherQ <= cfgDitherEn;
      replQ   <= cfgReplicateEn;
    end
  end

  always_comb begin
    ctrlS          = '0;
    ctrlS.load     = inValid;
    ctrlS.outWidth = widthQ;
    ctrlS.mode     = MODE_PASS;
    if (widthQ < NATIVE_W) begin
      ctrlS.mode     = ditherQ ? MODE_DITHER : MODE_TRUNC;
      ctrlS.dropBits = DROP_W'(NATIVE_W - widthQ);
    end else if (widthQ > NATIVE_W) begin
      ctrlS.mode      = replQ ? MODE_REPL : MODE_PAD;
      ctrlS.extraBits = EXTRA_W'(widthQ - NATIVE_W);
    end
  end
endmodule

// File: rtl/pdf_lane.sv
module pdf_lane
  import pdf_pkg::*;
(
  input  logic [COMP_W-1:0]    comp,
  input  fmtMode_e             mode,
  input  logic [WSEL_W-1:0]    outWidth,
  input  logic [DROP_W-1:0]    dropBits,
  input  logic [EXTRA_W-1:0]   extraBits,
  input  logic [THR_W-1:0]     threshold,
  output logic [MAX_OUT_W-1:0] result
);
  localparam logic [DROP_W-1:0] THR_SPAN = DROP_W'(THR_W);

  logic [COMP_W-1:0]    kept;
  logic [COMP_W-1:0]    keptMax;
  logic [COMP_W-1:0]    removed;
  logic [COMP_W-1:0]    scaledThr;
  logic [MAX_OUT_W-1:0] widened;
  logic [MAX_OUT_W-1:0] shiftedUp;
  logic [MAX_OUT_W-1:0] fillBits;
  logic                 roundUp;

  always_comb begin
    kept    = comp >> dropBits;
    keptMax = ~({COMP_W{1'b1}} << outWidth);
    removed = comp & ~({COMP_W{1'b1}} << dropBits);
    if (dropBits >= THR_SPAN)
      scaledThr = COMP_W'(threshold) << (dropBits - THR_SPAN);
    else
      scaledThr = COMP_W'(threshold) >> (THR_SPAN - dropBits);
    roundUp   = (removed > scaledThr) && (kept != keptMax);
    widened   = MAX_OUT_W'(comp);
    shiftedUp = widened << extraBits;
    fillBits  = MAX_OUT_W'(comp >> (COMP_W - int'(extraBits)));
    case (mode)
      MODE_TRUNC:  result = MAX_OUT_W'(kept);
      MODE_DITHER: result = MAX_OUT_W'(kept) + MAX_OUT_W'(roundUp);
      MODE_REPL:   result = shiftedUp | fillBits;
      MODE_PAD:    result = shiftedUp;
      default:     result = widened;
    endcase
  end
endmodule

// File: rtl/pdf_datapath.sv
module pdf_datapath
  import pdf_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  fmtCtrl_t                      ctrlS,
  input  logic [NUM_COMP*COMP_W-1:0]    inPixel,
  input  logic [1:0]                    colLow,
  input  logic [1:0]                    rowLow,
  input  logic [1:0]                    frameLow,
  output logic                          outValid,
  output logic [NUM_COMP*MAX_OUT_W-1:0] outPixel
);
  logic [1:0]                    colIdx;
  logic [1:0]                    rowIdx;
  logic [THR_W-1:0]              threshold;
  logic [NUM_COMP*MAX_OUT_W-1:0] nextPixel;

  always_comb begin
    colIdx    = colLow + frameLow;
    rowIdx    = rowLow + frameLow;
    threshold = orderedThreshold(colIdx, rowIdx);
  end

  for (genvar g = 0; g < NUM_COMP; g++) begin : gLane
    pdf_lane laneI (
      .comp      (inPixel[g*COMP_W +: COMP_W]),
      .mode      (ctrlS.mode),
      .outWidth  (ctrlS.outWidth),
      .dropBits  (ctrlS.dropBits),
      .extraBits (ctrlS.extraBits),
      .threshold (threshold),
      .result    (nextPixel[g*MAX_OUT_W +: MAX_OUT_W])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outPixel <= '0;
    end else begin
      outValid <= ctrlS.load;
      if (ctrlS.load) outPixel <= nextPixel;
    end
  end
endmodule

// File: rtl/pixel_depth_formatter.sv
module pixel_depth_formatter
  import pdf_pkg::*;
#(
  parameter int POS_W   = 12,
  parameter int FRAME_W = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          frameStart,
  input  logic [WSEL_W-1:0]             cfgOutWidth,
  input  logic                          cfgDitherEn,
  input  logic                          cfgReplicateEn,
  input  logic                          inValid,
  input  logic [NUM_COMP*COMP_W-1:0]    inPixel,
  input  logic [POS_W-1:0]              posX,
  input  logic [POS_W-1:0]              posY,
  input  logic [FRAME_W-1:0]            frameNum,
  output logic                          outValid,
  output logic [NUM_COMP*MAX_OUT_W-1:0] outPixel
);
  fmtCtrl_t ctrlS;
  logic     unusedHighBits;

  // only the two low bits of position and frame steer the matrix
  assign unusedHighBits = ^{posX[POS_W-1:2], posY[POS_W-1:2], frameNum[FRAME_W-1:2]};

  pdf_ctrl ctrlI (
    .clk            (clk),
    .rstN           (rstN),
    .frameStart     (frameStart),
    .cfgOutWidth    (cfgOutWidth),
    .cfgDitherEn    (cfgDitherEn),
    .cfgReplicateEn (cfgReplicateEn),
    .inValid        (inValid),
    .ctrlS          (ctrlS)
  );

  pdf_datapath dpI (
    .clk      (clk),
    .rstN     (rstN),
    .ctrlS    (ctrlS),
    .inPixel  (inPixel),
    .colLow   (posX[1:0]),
    .rowLow   (posY[1:0]),
    .frameLow (frameNum[1:0]),
    .outValid (outValid),
    .outPixel (outPixel)
  );
endmodule

// File: rtl/pdf_checker.sv
module pdf_checker
  import pdf_pkg::*;
(
  input logic                          clk,
  input logic                          rstN,
  input logic                          frameStart,
  input logic                          inValid,
  input logic                          outValid,
  input logic [NUM_COMP*MAX_OUT_W-1:0] outPixel,
  input logic [WSEL_W-1:0]             effWidth,
  input fmtMode_e                      ctrlMode
);
  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R1
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  // R2
  hold_pixel_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(outPixel));

  // R3
  cfg_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !frameStart |=> $stable(effWidth));

  // R3
  width_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (effWidth >= WSEL_W'(MIN_OUT_W)) && (effWidth <= WSEL_W'(MAX_OUT_W)));

  // R4
  lane_fit_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |->
      ((outPixel[MAX_OUT_W-1:0] >> $past(effWidth)) == '0) &&
      ((outPixel[2*MAX_OUT_W-1:MAX_OUT_W] >> $past(effWidth)) == '0) &&
      ((outPixel[3*MAX_OUT_W-1:2*MAX_OUT_W] >> $past(effWidth)) == '0));

  // R9
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && ($past(ctrlMode) == MODE_PAD)) |->
      (!outPixel[0] && !outPixel[MAX_OUT_W] && !outPixel[2*MAX_OUT_W]));
endmodule

bind pixel_depth_formatter pdf_checker chkI (
  .clk        (clk),
  .rstN       (rstN),
  .frameStart (frameStart),
  .inValid    (inValid),
  .outValid   (outValid),
  .outPixel   (outPixel),
  .effWidth   (ctrlS.outWidth),
  .ctrlMode   (ctrlS.mode)
);

// File: tb/pixel_depth_formatter_tb_top.sv
module pixel_depth_formatter_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameStart = 1'b0;
  logic [3:0]  cfgOutWidth = 4'd8;
  logic        cfgDitherEn = 1'b0;
  logic        cfgReplicateEn = 1'b0;
  logic        inValid = 1'b0;
  logic [23:0] inPixel = '0;
  logic [11:0] posX = '0;
  logic [11:0] posY = '0;
  logic [7:0]  frameNum = '0;
  logic        outValid;
  logic [29:0] outPixel;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pixel_depth_formatter dut_i (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .cfgOutWidth(cfgOutWidth),
    .cfgDitherEn(cfgDitherEn), .cfgReplicateEn(cfgReplicateEn), .inValid(inValid),
    .inPixel(inPixel), .posX(posX), .posY(posY), .frameNum(frameNum),
    .outValid(outValid), .outPixel(outPixel)
  );

  // fields: width, dither, replicate, x, y, frame, pixel, expected lanes
  localparam int NVEC = 12;
  localparam logic [65:0] VEC [NVEC] = '{
    {4'd8,  1'b1, 1'b0, 2'd0, 2'd0, 2'd0, 24'hA53CFF, 10'h0A5, 10'h03C, 10'h0FF},
    {4'd5,  1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 24'hA53CFF, 10'h014, 10'h007, 10'h01F},
    {4'd3,  1'b0, 1'b0, 2'd1, 2'd2, 2'd3, 24'hE01F80, 10'h007, 10'h000, 10'h004},
    {4'd10, 1'b0, 1'b1, 2'd0, 2'd0, 2'd0, 24'hA53CFF, 10'h296, 10'h0F0, 10'h3FF},
    {4'd10, 1'b1, 1'b0, 2'd0, 2'd0, 2'd0, 24'hA53CFF, 10'h294, 10'h0F0, 10'h3FC},
    {4'd9,  1'b0, 1'b1, 2'd0, 2'd0, 2'd0, 24'hA53C01, 10'h14B, 10'h078, 10'h002},
    {4'd6,  1'b1, 1'b0, 2'd0, 2'd0, 2'd0, 24'hA53CFF, 10'h02A, 10'h00F, 10'h03F},
    {4'd4,  1'b1, 1'b0, 2'd1, 2'd2, 2'd0, 24'hAC3B5F, 10'h00B, 10'h003, 10'h006},
    {4'd4,  1'b1, 1'b0, 2'd1, 2'd2, 2'd1, 24'hAC3E5D, 10'h00A, 10'h004, 10'h005},
    {4'd3,  1'b1, 1'b0, 2'd3, 2'd3, 2'd2, 24'h8948FF, 10'h005, 10'h002, 10'h007},
    {4'd7,  1'b1, 1'b0, 2'd2, 2'd0, 2'd0, 24'h0102FE, 10'h001, 10'h001, 10'h07F},
    {4'd5,  1'b1, 1'b0, 2'd0, 2'd0, 2'd3, 24'h131207, 10'h003, 10'h002, 10'h001}
  };

  function automatic string tagFor(input logic [3:0] w, input logic d, input logic r);
    if (w < 4'd8) return d ? "R6" : "R5";
    if (w > 4'd8) return r ? "R8" : "R9";
    return "R9";
  endfunction

  task automatic chkVec(input string tag, input logic [29:0] act, input logic [29:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: outPixel actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chkBit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: outValid actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic applyCfg(input logic [3:0] w, input logic d, input logic r);
    @(negedge clk);
    cfgOutWidth = w; cfgDitherEn = d; cfgReplicateEn = r; frameStart = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
  endtask

  task automatic sendPixel(input logic [23:0] pix, input logic [11:0] x, input logic [11:0] y,
                           input logic [7:0] f, input logic [29:0] exp, input string tag);
    @(negedge clk);
    inPixel = pix; posX = x; posY = y; frameNum = f; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    chkBit(tag, outValid, 1'b1);
    chkVec(tag, outPixel, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chkBit("R1", outValid, 1'b0);
    chkVec("R1", outPixel, 30'h0);
    rstN = 1'b1;
    @(negedge clk);
    chkBit("R1", outValid, 1'b0);

    // R3 default is 8-bit pass-through
    sendPixel(24'h123456, 12'h0, 12'h0, 8'h0, {10'h012, 10'h034, 10'h056}, "R3");

    // R3 settings without frameStart are not taken up
    @(negedge clk);
    cfgOutWidth = 4'd4; cfgDitherEn = 1'b1; cfgReplicateEn = 1'b1;
    sendPixel(24'hA53CFF, 12'h0, 12'h0, 8'h0, {10'h0A5, 10'h03C, 10'h0FF}, "R3");

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      applyCfg(VEC[i][65:62], VEC[i][61], VEC[i][60]);
      sendPixel(VEC[i][53:30], {10'h010, VEC[i][59:58]}, {10'h020, VEC[i][57:56]},
                {6'h15, VEC[i][55:54]}, VEC[i][29:0],
                tagFor(VEC[i][65:62], VEC[i][61], VEC[i][60]));
    end

    // R3 clamping above and below the range
    applyCfg(4'd15, 1'b0, 1'b1);
    sendPixel(24'hA53CFF, 12'h0, 12'h0, 8'h0, {10'h296, 10'h0F0, 10'h3FF}, "R3");
    applyCfg(4'd0, 1'b0, 1'b0);
    sendPixel(24'hE01F80, 12'h0, 12'h0, 8'h0, {10'h007, 10'h000, 10'h004}, "R3");

    // R7 saturation at all-ones
    applyCfg(4'd5, 1'b1, 1'b0);
    sendPixel(24'hFFF9F8, 12'h0, 12'h0, 8'h0, {10'h01F, 10'h01F, 10'h01F}, "R7");

    // R2 hold while idle, other inputs moving
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chkBit("R2", outValid, 1'b0);
      chkVec("R2", outPixel, {10'h01F, 10'h01F, 10'h01F});
      inPixel = 24'h000000 + 24'(k * 24'h111111);
      posX = 12'(k); frameNum = 8'(k);
    end

    // R1 back-to-back pixels, one cycle each
    applyCfg(4'd8, 1'b0, 1'b0);
    @(negedge clk);
    inPixel = 24'h010203; inValid = 1'b1;
    @(negedge clk);
    chkBit("R1", outValid, 1'b1);
    chkVec("R1", outPixel, {10'h001, 10'h002, 10'h003});
    inPixel = 24'hF0E0D0;
    @(negedge clk);
    inValid = 1'b0;
    chkBit("R1", outValid, 1'b1);
    chkVec("R1", outPixel, {10'h0F0, 10'h0E0, 10'h0D0});
    @(negedge clk);
    chkBit("R1", outValid, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule